// File: doc/BRIEF.md
# One-Time-Programmable Fuse Sequencer

This block controls a one-time-programmable fuse store of 96 words, each 32 bits wide. A host drives it through a small register bus. The host first raises a power request. Once the store reports that it is powered, the host issues commands through a control register. A read command copies one word out to a shadow bank. A program command ORs the staged write data into one word. A lock command permanently blocks further programming of one word. The fuse store itself is a behavioural model held inside the design. Its bits can only move from 0 to 1, and every operation keeps the block busy for a fixed number of cycles.

Lock state is kept in a separate set of sixteen-bit lock rows. Each of the 32 lower words owns a pair of adjacent lock bits, packed eight words to a row. Each upper word owns a single bit, packed sixteen words to a row, in the rows that follow the lower ones. A host-writable global lock can also veto all program commands until reset.

When a read finishes, the block raises a one-cycle load strobe. The word index and the fuse data are presented with it, so that a shadow bank can capture the word.

Top module: `otp_fuse_top`

## Requirements
- R1: After reset, every register reads zero, the status register reads zero, the load strobe is low, and every fuse and lock bit is 0.
- R2: Configuration register bit 0 (offset 0x00) is the power request. Status bit 5 takes the value of the request once the request has differed from it for PWR_LAT consecutive clock edges. This applies to power-up and to power-down alike.
- R3: Writing the control register (offset 0x04) with bits 9 and 8 both clear starts a read of the word whose index is in bits 6:0. Busy (status bit 3) is set for exactly BUSY_LAT cycles. In the cycle busy falls, the load strobe is high for one cycle, carrying the index and the fuse word.
- R4: Control bit 8 set with bit 9 clear starts a program command. When the command completes, the word becomes its old value ORed with the write-data register (offset 0x08).
- R5: The status register sits at offset 0x0C. Bit 3 is busy, bit 4 is command-failed, and bit 5 is powered. All other bits read 0.
- R6: A command is not started, and status bit 4 is set with busy left clear, in two cases: its index is above 95, or the store is unpowered when the command is written.
- R7: While busy is set, writes to the control register are ignored and start nothing. Writes to the write-data register are also ignored while busy is set.
- R8: Bit 4 of the lock register (offset 0x10) is a global program lock. Writing it with 1 sets it, and only reset clears it. While it is set, a program command is ignored without setting the fail bit. Reads and lock commands still run.
- R9: Control bit 9 set starts a lock command. Word n below 32 sets bits 2(n mod 8) and 2(n mod 8)+1 of lock row n/8. Word n of 32 or above sets bit n mod 16 of lock row 4+(n-32)/16. A program command to a word with any of its lock bits set is refused: nothing starts and status bit 4 is set.
- R10: Every command that starts clears status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write enable, qualified by busSel |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| loadStrobe | output | 1 | One-cycle pulse when a read completes |
| loadIndex | output | 7 | Word index of the completed read |
| loadData | output | 32 | Fuse word of the completed read |

## Verification
A control write is sampled at a clock edge.
- Busy and fail show up in the status register directly after that edge.
- Busy then stays high across the next BUSY_LAT-1 edges. It falls at the BUSY_LAT-th edge, and the load strobe rises on that same edge for one cycle.
- Powered changes on the PWR_LAT-th edge after the request changes.

The bench checks these results in two ways. It runs a behavioural model that applies these rules edge by edge, and it compares the model with the read data and the load outputs two time units after every rising edge. It also makes explicit status reads on the cycle just before each of these edges and on the cycle just after.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 96;
  localparam int UPPER_BASE  = 32;
  localparam int IDX_W       = $clog2(NUM_WORDS);
  localparam int LOCK_W      = 16;
  localparam int LOW_PER_ROW = LOCK_W / 2;
  localparam int LOCK_ROWS   = UPPER_BASE / LOW_PER_ROW + (NUM_WORDS - UPPER_BASE + LOCK_W - 1) / LOCK_W;
  localparam int ROW_W       = $clog2(LOCK_ROWS);
  localparam int ADDR_W      = 8;

  localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] A_WDATA = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_LOCK  = 8'h10;

  localparam int CTRL_PROG_BIT = 8;
  localparam int CTRL_LOCK_BIT = 9;
  localparam int ST_BUSY       = 3;
  localparam int ST_FAIL       = 4;
  localparam int ST_PWR        = 5;
  localparam int GLOCK_BIT     = 4;

  typedef struct packed {
    logic             busy;
    logic             doRead;
    logic             doProg;
    logic             doLock;
    logic [IDX_W-1:0] idx;
  } otpStrobes_t;

  // Row of the lock store that guards word n
  function automatic logic [ROW_W-1:0] lockRow(input logic [IDX_W-1:0] n);
    int r;
    if (int'(n) < UPPER_BASE) r = int'(n) / LOW_PER_ROW;
    else                      r = UPPER_BASE / LOW_PER_ROW + (int'(n) - UPPER_BASE) / LOCK_W;
    return ROW_W'(r);
  endfunction

  // Bits inside that row: a pair for lower words, a single bit for upper words
  function automatic logic [LOCK_W-1:0] lockMask(input logic [IDX_W-1:0] n);
    if (int'(n) < UPPER_BASE) return LOCK_W'(3) << ((2 * int'(n)) % LOCK_W);
    else                      return LOCK_W'(1) << (int'(n) % LOCK_W);
  endfunction
endpackage

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int BUSY_LAT = 16,
  parameter int PWR_LAT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              cmdLocked,
  input  logic              gLock,
  output otpStrobes_t       strb,
  output logic              powerReq,
  output logic              powered,
  output logic              failFlag
);
  localparam int BCNT_W = $clog2(BUSY_LAT + 1);
  localparam int PCNT_W = $clog2(PWR_LAT + 1);

  logic              busy;
  logic [BCNT_W-1:0] busyCnt;
  logic [PCNT_W-1:0] pwrCnt;
  logic              opRead, opProg, opLock;
  logic [IDX_W-1:0]  opIdx;

  logic             cfgWr, ctrlWr;
  logic [IDX_W-1:0] cmdIdx;
  logic             cmdIsLock, cmdIsProg, cmdIsRead, inRange;
  logic             cmdAccept, cmdRefuse, opDone;

  always_comb begin
    cfgWr     = busSel & busWr & (busAddr == A_CFG);
    ctrlWr    = busSel & busWr & (busAddr == A_CTRL);
    cmdIdx    = busWdata[IDX_W-1:0];
    cmdIsLock = busWdata[CTRL_LOCK_BIT];
    cmdIsProg = busWdata[CTRL_PROG_BIT] & ~busWdata[CTRL_LOCK_BIT];
    cmdIsRead = ~busWdata[CTRL_PROG_BIT] & ~busWdata[CTRL_LOCK_BIT];
    inRange   = int'(cmdIdx) < NUM_WORDS;
    cmdRefuse = ctrlWr & ~busy &
                (~inRange | ~powered | (cmdIsProg & ~gLock & cmdLocked));
    cmdAccept = ctrlWr & ~busy & inRange & powered &
                ~(cmdIsProg & (gLock | cmdLocked));
    opDone    = busy & (busyCnt == '0);
  end

  // Power handshake: the powered flag follows the request after PWR_LAT edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerReq <= 1'b0;
      powered  <= 1'b0;
      pwrCnt   <= '0;
    end else begin
      if (cfgWr) powerReq <= busWdata[0];
      if (powerReq != powered) begin
        if (pwrCnt == PCNT_W'(PWR_LAT - 1)) begin
          powered <= powerReq;
          pwrCnt  <= '0;
        end else begin
          pwrCnt <= pwrCnt + 1'b1;
        end
      end else begin
        pwrCnt <= '0;
      end
    end
  end

  // Command sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      busyCnt  <= '0;
      opRead   <= 1'b0;
      opProg   <= 1'b0;
      opLock   <= 1'b0;
      opIdx    <= '0;
      failFlag <= 1'b0;
    end else begin
      if (cmdAccept) begin
        busy     <= 1'b1;
        busyCnt  <= BCNT_W'(BUSY_LAT - 1);
        opRead   <= cmdIsRead;
        opProg   <= cmdIsProg;
        opLock   <= cmdIsLock;
        opIdx    <= cmdIdx;
        failFlag <= 1'b0;
      end else begin
        if (cmdRefuse) failFlag <= 1'b1;
        if (opDone) busy <= 1'b0;
        else if (busy) busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.busy   = busy;
    strb.doRead = opDone & opRead;
    strb.doProg = opDone & opProg;
    strb.doLock = opDone & opLock;
    strb.idx    = opIdx;
  end

  AST_FAIL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN) failFlag |-> !busy); // R6
  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(powered)); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (busy && busyCnt != '0) |=> busy); // R3
  AST_POWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) $rose(powered) |-> $past(powerReq)); // R2
endmodule

// File: rtl/otp_fuse_dp.sv
module otp_fuse_dp
  import otp_fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  otpStrobes_t       strb,
  input  logic              powerReq,
  input  logic              powered,
  input  logic              failFlag,
  output logic              cmdLocked,
  output logic              gLock,
  output logic [WORD_W-1:0] busRdata,
  output logic              loadStrobe,
  output logic [IDX_W-1:0]  loadIndex,
  output logic [WORD_W-1:0] loadData
);
  logic [WORD_W-1:0] fuse    [NUM_WORDS];
  logic [LOCK_W-1:0] lockFuse[LOCK_ROWS];
  logic [WORD_W-1:0] wdataReg;
  logic [IDX_W-1:0]  qIdx;

  // Staged write data and the sticky global program lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdataReg <= '0;
      gLock    <= 1'b0;
    end else if (busSel && busWr) begin
      if (busAddr == A_WDATA && !strb.busy) wdataReg <= busWdata;
      if (busAddr == A_LOCK && busWdata[GLOCK_BIT]) gLock <= 1'b1;
    end
  end

  // Data fuses: bits only ever move from 0 to 1
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) fuse[w] <= '0;
      else if (strb.doProg && strb.idx == IDX_W'(w)) fuse[w] <= fuse[w] | wdataReg;
    end
    AST_FUSE_ONLY_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (fuse[w] & $past(fuse[w])) == $past(fuse[w])); // R4
  end

  // Lock fuses, one row per group of words
  for (genvar r = 0; r < LOCK_ROWS; r++) begin : g_lockrow
    always_ff @(posedge clk) begin
      if (!rstN) lockFuse[r] <= '0;
      else if (strb.doLock && lockRow(strb.idx) == ROW_W'(r))
        lockFuse[r] <= lockFuse[r] | lockMask(strb.idx);
    end
  end

  always_comb begin
    qIdx      = busWdata[IDX_W-1:0];
    cmdLocked = 1'b0;
    if (int'(qIdx) < NUM_WORDS)
      cmdLocked = |(lockFuse[lockRow(qIdx)] & lockMask(qIdx));
  end

  // Shadow load port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStrobe <= 1'b0;
      loadIndex  <= '0;
      loadData   <= '0;
    end else begin
      loadStrobe <= strb.doRead;
      if (strb.doRead) begin
        loadIndex <= strb.idx;
        loadData  <= fuse[strb.idx];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CFG:   busRdata[0] = powerReq;
      A_WDATA: busRdata = wdataReg;
      A_STAT: begin
        busRdata[ST_BUSY] = strb.busy;
        busRdata[ST_FAIL] = failFlag;
        busRdata[ST_PWR]  = powered;
      end
      A_LOCK:  busRdata[GLOCK_BIT] = gLock;
      default: busRdata = '0;
    endcase
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) loadStrobe |=> !loadStrobe); // R3
  AST_GLOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN) $past(gLock) |-> gLock); // R8
  AST_WDATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN) $past(strb.busy) |-> $stable(wdataReg)); // R7
endmodule

// File: rtl/otp_fuse_top.sv
module otp_fuse_top
  import otp_fuse_pkg::*;
#(
  parameter int BUSY_LAT = 16,
  parameter int PWR_LAT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              loadStrobe,
  output logic [IDX_W-1:0]  loadIndex,
  output logic [WORD_W-1:0] loadData
);
  otpStrobes_t strb;
  logic        powerReq, powered, failFlag, cmdLocked, gLock;

  otp_fuse_ctrl #(.BUSY_LAT(BUSY_LAT), .PWR_LAT(PWR_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .cmdLocked(cmdLocked), .gLock(gLock), .strb(strb),
    .powerReq(powerReq), .powered(powered), .failFlag(failFlag)
  );

  otp_fuse_dp u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strb(strb), .powerReq(powerReq), .powered(powered),
    .failFlag(failFlag), .cmdLocked(cmdLocked), .gLock(gLock), .busRdata(busRdata),
    .loadStrobe(loadStrobe), .loadIndex(loadIndex), .loadData(loadData)
  );
endmodule

// File: tb/otp_fuse_top_bench.sv
module otp_fuse_top_bench;
  localparam int PERIOD   = 10;
  localparam int BUSY_LAT = 16;
  localparam int PWR_LAT  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = 8'h0C;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        loadStrobe;
  logic [6:0]  loadIndex;
  logic [31:0] loadData;

  int    nChecks = 0, nErr = 0, nStrobes = 0;
  bit    done = 0;
  string curReq = "R1";
  logic [6:0]  lastIdx;
  logic [31:0] lastData;

  otp_fuse_top #(.BUSY_LAT(BUSY_LAT), .PWR_LAT(PWR_LAT)) u_otp_fuse_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .loadStrobe(loadStrobe),
    .loadIndex(loadIndex), .loadData(loadData)
  );

  always #(PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic        mReq, mPwr, mBusy, mFail, mGlock, mStrobe;
  int          mPcnt, mBcnt, mOp, mOpIdx, mIdx;
  logic [31:0] mWdata, mData;
  logic [31:0] mFuse[96];
  logic [15:0] mLockF[8];

  function automatic bit mIsLocked(int n);
    if (n < 32) return mLockF[n/8][2*(n%8)] | mLockF[n/8][2*(n%8)+1];
    return mLockF[4 + (n-32)/16][n%16];
  endfunction

  function automatic logic [31:0] mRd(logic [7:0] a);
    case (a)
      8'h00: return {31'b0, mReq};
      8'h08: return mWdata;
      8'h0C: return (mBusy ? 32'h8 : 32'h0) | (mFail ? 32'h10 : 32'h0) | (mPwr ? 32'h20 : 32'h0);
      8'h10: return mGlock ? 32'h10 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic oldBusy, oldPwr, oldReq;
    int n;
    if (!rstN) begin
      mReq = 0; mPwr = 0; mBusy = 0; mFail = 0; mGlock = 0; mStrobe = 0;
      mPcnt = 0; mBcnt = 0; mOp = 0; mOpIdx = 0; mIdx = 0; mWdata = 0; mData = 0;
      for (int i = 0; i < 96; i++) mFuse[i] = 0;
      for (int i = 0; i < 8; i++) mLockF[i] = 0;
    end else begin
      oldBusy = mBusy; oldPwr = mPwr; oldReq = mReq; mStrobe = 0;
      if (busSel && busWr) begin
        case (busAddr)
          8'h00: mReq = busWdata[0];
          8'h08: if (!oldBusy) mWdata = busWdata;
          8'h10: if (busWdata[4]) mGlock = 1;
          8'h04: if (!oldBusy) begin
            n = int'(busWdata[6:0]);
            if (n > 95 || !oldPwr) mFail = 1;
            else begin
              if (busWdata[9]) mOp = 2;
              else if (busWdata[8]) mOp = 1;
              else mOp = 0;
              if (mOp == 1 && mGlock) ;
              else if (mOp == 1 && mIsLocked(n)) mFail = 1;
              else begin mBusy = 1; mBcnt = BUSY_LAT; mFail = 0; mOpIdx = n; end
            end
          end
          default: ;
        endcase
      end
      if (oldBusy) begin
        mBcnt--;
        if (mBcnt == 0) begin
          mBusy = 0;
          if (mOp == 0) begin mStrobe = 1; mIdx = mOpIdx; mData = mFuse[mOpIdx]; end
          else if (mOp == 1) mFuse[mOpIdx] = mFuse[mOpIdx] | mWdata;
          else if (mOpIdx < 32) begin
            mLockF[mOpIdx/8][2*(mOpIdx%8)] = 1;
            mLockF[mOpIdx/8][2*(mOpIdx%8)+1] = 1;
          end else mLockF[4 + (mOpIdx-32)/16][mOpIdx%16] = 1;
        end
      end
      if (oldReq != mPwr) begin
        mPcnt++;
        if (mPcnt == PWR_LAT) begin mPwr = oldReq; mPcnt = 0; end
      end else mPcnt = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, two time units after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (rstN && !done) begin
      chk(busRdata == mRd(busAddr), curReq, busRdata, mRd(busAddr), "model rdata");
      chk(loadStrobe == mStrobe, curReq, 32'(loadStrobe), 32'(mStrobe), "model strobe");
      if (loadStrobe) begin
        nStrobes++;
        lastIdx = loadIndex; lastData = loadData;
        if (mStrobe) begin
          chk(int'(loadIndex) == mIdx, curReq, 32'(loadIndex), 32'(mIdx), "model index");
          chk(loadData == mData, curReq, loadData, mData, "model data");
        end
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busAddr = 8'h0C; busWdata = '0;
  endtask

  task automatic rdCheck(logic [7:0] a, logic [31:0] exp, string req);
    busAddr = a;
    #1;
    chk(busRdata == exp, req, busRdata, exp, "register read");
    busAddr = 8'h0C;
  endtask

  task automatic cmd(logic [31:0] v);
    busWrite(8'h04, v);
    waitCycles(BUSY_LAT + 2);
  endtask

  initial begin
    int s0;
    waitCycles(3);
    rstN = 1;
    waitCycles(3);
    // R1 reset state
    rdCheck(8'h0C, 32'h0, "R1");
    rdCheck(8'h00, 32'h0, "R1");
    rdCheck(8'h08, 32'h0, "R1");
    rdCheck(8'h10, 32'h0, "R1");
    chk(loadStrobe == 0, "R1", 32'(loadStrobe), 0, "strobe after reset");

    // R6 read while unpowered
    curReq = "R6";
    cmd(32'h3);
    rdCheck(8'h0C, 32'h10, "R6");

    // R2 power-up delay
    curReq = "R2";
    busWrite(8'h00, 32'h1);
    rdCheck(8'h00, 32'h1, "R2");
    waitCycles(PWR_LAT - 1);
    rdCheck(8'h0C, 32'h10, "R2");
    waitCycles(1);
    rdCheck(8'h0C, 32'h30, "R2");

    // R3 / R10 read timing; R5 status bit positions
    curReq = "R3";
    busWrite(8'h04, 32'h3);
    rdCheck(8'h0C, 32'h28, "R10");
    waitCycles(BUSY_LAT - 1);
    rdCheck(8'h0C, 32'h28, "R3");
    waitCycles(1);
    rdCheck(8'h0C, 32'h20, "R5");
    chk(loadStrobe == 1, "R3", 32'(loadStrobe), 1, "strobe at completion");
    chk(loadIndex == 7'd3, "R3", 32'(loadIndex), 3, "strobe index");
    waitCycles(1);
    chk(loadStrobe == 0, "R3", 32'(loadStrobe), 0, "strobe one cycle");

    // R4 program, R7 writes ignored while busy
    curReq = "R4";
    busWrite(8'h08, 32'hA5A5_0F0F);
    s0 = nStrobes;
    busWrite(8'h04, 32'h103);
    busWrite(8'h04, 32'h7);
    busWrite(8'h08, 32'hFFFF_FFFF);
    rdCheck(8'h08, 32'hA5A5_0F0F, "R7");
    waitCycles(BUSY_LAT);
    chk(nStrobes == s0, "R7", 32'(nStrobes), 32'(s0), "no strobe from ignored read");
    cmd(32'h3);
    chk(lastData == 32'hA5A5_0F0F, "R4", lastData, 32'hA5A5_0F0F, "programmed word");
    busWrite(8'h08, 32'h0000_F0F0);
    cmd(32'h103);
    cmd(32'h3);
    chk(lastData == 32'hA5A5_FFFF, "R4", lastData, 32'hA5A5_FFFF, "OR into word");

    // R6 index range, R10 clear
    curReq = "R6";
    cmd(32'd100);
    rdCheck(8'h0C, 32'h30, "R6");
    curReq = "R9";
    cmd(32'h205);
    rdCheck(8'h0C, 32'h20, "R10");

    // R9 lock encoding
    busWrite(8'h08, 32'h1);
    cmd(32'h105);
    rdCheck(8'h0C, 32'h30, "R9");
    cmd(32'h104);
    rdCheck(8'h0C, 32'h20, "R9");
    cmd(32'h106);
    cmd(32'h10D);
    rdCheck(8'h0C, 32'h20, "R9");
    cmd(32'h5);
    chk(lastData == 32'h0, "R9", lastData, 0, "refused word unchanged");
    cmd(32'h4);
    chk(lastData == 32'h1, "R9", lastData, 1, "neighbour programmed");
    cmd(32'h225);
    cmd(32'h125);
    rdCheck(8'h0C, 32'h30, "R9");
    cmd(32'h124);
    rdCheck(8'h0C, 32'h20, "R9");
    cmd(32'h228);
    cmd(32'h138);
    rdCheck(8'h0C, 32'h20, "R9");
    cmd(32'd56);
    chk(lastData == 32'h1, "R9", lastData, 1, "upper row addressing");

    // R8 global program lock
    curReq = "R8";
    busWrite(8'h10, 32'h10);
    busWrite(8'h10, 32'h0);
    rdCheck(8'h10, 32'h10, "R8");
    busWrite(8'h08, 32'hFF);
    busWrite(8'h04, 32'h109);
    rdCheck(8'h0C, 32'h20, "R8");
    waitCycles(BUSY_LAT + 2);
    cmd(32'h9);
    chk(lastData == 32'h0, "R8", lastData, 0, "program ignored under global lock");
    busWrite(8'h04, 32'h209);
    rdCheck(8'h0C, 32'h28, "R8");
    waitCycles(BUSY_LAT + 2);

    // R2 power-down, then R6 unpowered program
    curReq = "R2";
    busWrite(8'h00, 32'h0);
    waitCycles(PWR_LAT - 1);
    rdCheck(8'h0C, 32'h20, "R2");
    waitCycles(1);
    rdCheck(8'h0C, 32'h00, "R2");
    curReq = "R6";
    cmd(32'h103);
    rdCheck(8'h0C, 32'h10, "R6");

    waitCycles(2);
    finishRun();
  end
endmodule